// File: doc/BRIEF.md
# Multichannel Sample Word Packer

This block takes narrow samples from a set of parallel converter lanes and packs them into one wide word for an internal bus. All lanes share one input handshake. A per-lane enable mask selects which lanes take part. At each accepted time step, the enabled lanes are written in ascending lane order into the next free fields of the word. The fields fill from the least significant end upward. When the last field is written, the word is presented on a valid/ready output. Lanes that are disabled take no field at all, so a lone enabled lane packs exactly as a one-lane source would.

The lane count `NCHAN` must be a power of two. `WOUT` must be a multiple of `WIN*NCHAN`, and an elaboration check rejects any other setting. The enable mask is registered. In the cycle after the mask changes, the block discards any partly filled word and restarts at the lowest field. An enabled population that is zero or not a power of two is refused: the block raises an error flag and accepts no samples until a legal mask is applied. The whole block runs in one clock domain and has a synchronous active-high reset.

Back-pressure works as follows. A finished word stays on `pk_data`, with `pk_valid` high, until a cycle in which `pk_ready` is high. During that wait `smp_ready` is low, so no sample is lost and no word is overwritten.

Top module: `adc_lane_packer`

## Requirements
- R1: With one enabled lane, successive accepted samples go into field 0 (`pk_data[WIN-1:0]`), then field 1, and so on up to field `WOUT/WIN-1`. The next word then starts again at field 0.
- R2: With k enabled lanes, each accepted step writes k consecutive fields, lowest enabled lane first. A word therefore holds `WOUT/(WIN*k)` steps, ordered step by step.
- R3: A single enabled lane gives the same field layout and the same word rate, whichever lane index it is.
- R4: `pk_valid` rises in the cycle after the step that writes the last field is accepted. If `pk_ready` is high, it stays high for exactly one cycle.
- R5: While `pk_valid` is high and `pk_ready` is low, `pk_valid` stays high, `pk_data` holds its value and `smp_ready` is low.
- R6: In any cycle where `lane_en` differs from its value in the previous cycle, `smp_ready` is low. The partly filled word is dropped, and the next word holds only samples taken under the new mask.
- R7: If the registered mask has zero enabled lanes, or a population that is not a power of two, `cfg_err` is high and `smp_ready` is low. No new word is produced.
- R8: After reset, `pk_valid` is low, the fill position is field 0, and the registered mask equals `lane_en`. With a legal, steady mask, `cfg_err` is low and `smp_ready` is high.
- R9: `pk_data` changes only at the clock edge that raises or renews `pk_valid`. At all other times it holds the last finished word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | NCHAN | Per-lane enable mask |
| smp_valid | input | 1 | Sample set on `smp_data` is valid |
| smp_ready | output | 1 | Block accepts the sample set this cycle |
| smp_data | input | NCHAN*WIN | Lane c occupies bits `[c*WIN +: WIN]` |
| pk_valid | output | 1 | Packed word available |
| pk_ready | input | 1 | Consumer takes the packed word |
| pk_data | output | WOUT | Packed word |
| cfg_err | output | 1 | Enabled-lane population is illegal |

## Verification
The assertions assume that reset is applied for at least one cycle before activity starts. They also assume that `lane_en` is a registered, glitch-free control that may change in any cycle, and that `pk_ready` may be withdrawn while a word is pending. The stimulus drives every input at the falling edge and sends counting-pattern samples, so each field identifies its lane and its step. Mask changes land both in the middle of a word and on a word boundary. Illegal masks, including an empty one, are applied for several cycles with `smp_valid` held high, and the consumer is stalled across several cycles while the input keeps offering samples.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;

  function automatic int unsigned ones32(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

  function automatic logic legal_pop(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/adc_pack_cfg.sv
module adc_pack_cfg
  import adc_pack_pkg::*;
#(
  parameter int NCHAN = 4,
  localparam int CW = $clog2(NCHAN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCHAN-1:0] lane_en,
  output logic [NCHAN-1:0] mask_q,
  output logic [CW-1:0]    active_n,
  output logic             restart,
  output logic             bad_mask
);
  // Mask register: follows lane_en one cycle later, loaded during reset too
  always_ff @(posedge clk) begin
    mask_q <= lane_en;
  end

  int unsigned pop;
  always_comb begin
    pop = ones32(32'(mask_q));
    active_n = CW'(pop);
    bad_mask = !legal_pop(pop);
  end

  assign restart = (lane_en != mask_q) && !rst;
endmodule

// File: rtl/adc_pack_compact.sv
module adc_pack_compact #(
  parameter int NCHAN = 4,
  parameter int WIN   = 8,
  localparam int BUSW = NCHAN * WIN
) (
  input  logic [NCHAN-1:0] mask,
  input  logic [BUSW-1:0]  lanes,
  output logic [BUSW-1:0]  slots
);
  // Slot j carries the j-th enabled lane, in ascending lane order
  logic [BUSW-1:0] tmp;
  int slot;
  always_comb begin
    tmp  = '0;
    slot = 0;
    for (int c = 0; c < NCHAN; c++) begin
      if (mask[c]) begin
        tmp[slot*WIN +: WIN] = lanes[c*WIN +: WIN];
        slot++;
      end
    end
    slots = tmp;
  end
endmodule

// File: rtl/adc_pack_word.sv
module adc_pack_word #(
  parameter int NCHAN  = 4,
  parameter int WIN    = 8,
  parameter int NFIELD = 8,
  localparam int CW   = $clog2(NCHAN + 1),
  localparam int PW   = $clog2(NFIELD + 1),
  localparam int BUSW = NCHAN * WIN,
  localparam int OW   = NFIELD * WIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic            restart,
  input  logic [CW-1:0]   active_n,
  input  logic [BUSW-1:0] slots,
  input  logic            take,
  output logic            word_valid,
  output logic [OW-1:0]   word,
  output logic [PW-1:0]   fill_pos
);
  logic [WIN-1:0] stage   [NFIELD];
  logic [WIN-1:0] stage_n [NFIELD];
  logic [OW-1:0]  flat_n;
  logic           last_step;

  // Merge the new slots into the fields starting at fill_pos
  always_comb begin
    for (int f = 0; f < NFIELD; f++) begin
      stage_n[f] = stage[f];
      for (int k = 0; k < NCHAN; k++) begin
        if (k < int'(active_n) && f == int'(fill_pos) + k)
          stage_n[f] = slots[k*WIN +: WIN];
      end
    end
  end

  generate
    for (genvar g = 0; g < NFIELD; g++) begin : g_flat
      assign flat_n[g*WIN +: WIN] = stage_n[g];
    end
  endgenerate

  assign last_step = (int'(fill_pos) + int'(active_n)) >= NFIELD;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_pos   <= '0;
      word_valid <= 1'b0;
      word       <= '0;
      for (int f = 0; f < NFIELD; f++) stage[f] <= '0;
    end else begin
      if (word_valid && take) word_valid <= 1'b0;
      if (restart) begin
        fill_pos <= '0;
      end else if (accept) begin
        stage <= stage_n;
        if (last_step) begin
          fill_pos   <= '0;
          word_valid <= 1'b1;
          word       <= flat_n;
        end else begin
          fill_pos <= PW'(int'(fill_pos) + int'(active_n));
        end
      end
    end
  end
endmodule

// File: rtl/adc_lane_packer.sv
module adc_lane_packer #(
  parameter int NCHAN = 4,
  parameter int WIN   = 8,
  parameter int WOUT  = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCHAN-1:0]     lane_en,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [NCHAN*WIN-1:0] smp_data,
  output logic                 pk_valid,
  input  logic                 pk_ready,
  output logic [WOUT-1:0]      pk_data,
  output logic                 cfg_err
);
  localparam int NFIELD = WOUT / WIN;
  localparam int CW     = $clog2(NCHAN + 1);
  localparam int PW     = $clog2(NFIELD + 1);

  generate
    if ((NCHAN & (NCHAN - 1)) != 0 || NCHAN < 1) begin : g_bad_nchan
      $error("lane count must be a power of two");
    end
    if (WOUT % (WIN * NCHAN) != 0) begin : g_bad_wout
      $error("output width must be a multiple of WIN*NCHAN");
    end
  endgenerate

  logic [NCHAN-1:0]     mask_q;
  logic [CW-1:0]        active_n;
  logic                 restart;
  logic                 bad_mask;
  logic [NCHAN*WIN-1:0] slots;
  logic                 accept;
  logic [PW-1:0]        fill_pos;

  adc_pack_cfg #(.NCHAN(NCHAN)) u_cfg (
    .clk(clk), .rst(rst), .lane_en(lane_en), .mask_q(mask_q),
    .active_n(active_n), .restart(restart), .bad_mask(bad_mask)
  );

  adc_pack_compact #(.NCHAN(NCHAN), .WIN(WIN)) u_cmp (
    .mask(mask_q), .lanes(smp_data), .slots(slots)
  );

  assign cfg_err   = bad_mask;
  assign smp_ready = !rst && !bad_mask && !restart && !(pk_valid && !pk_ready);
  assign accept    = smp_valid && smp_ready;

  adc_pack_word #(.NCHAN(NCHAN), .WIN(WIN), .NFIELD(NFIELD)) u_word (
    .clk(clk), .rst(rst), .accept(accept), .restart(restart),
    .active_n(active_n), .slots(slots), .take(pk_ready),
    .word_valid(pk_valid), .word(pk_data), .fill_pos(fill_pos)
  );
endmodule

// File: rtl/adc_lane_packer_chk.sv
module adc_lane_packer_chk #(
  parameter int NCHAN  = 4,
  parameter int WOUT   = 64,
  parameter int NFIELD = 8,
  parameter int PW     = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NCHAN-1:0] lane_en,
  input logic             smp_ready,
  input logic             pk_valid,
  input logic             pk_ready,
  input logic [WOUT-1:0]  pk_data,
  input logic             cfg_err,
  input logic [PW-1:0]    fill_pos
);
  a_r1_fill_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(fill_pos) < NFIELD);

  a_r5_word_held: assert property (@(posedge clk) disable iff (rst)
    pk_valid && !pk_ready |=> pk_valid && $stable(pk_data));

  a_r5_input_stalled: assert property (@(posedge clk) disable iff (rst)
    pk_valid && !pk_ready |-> !smp_ready);

  a_r6_mask_change_gates: assert property (@(posedge clk) disable iff (rst)
    !$stable(lane_en) |-> !smp_ready);

  a_r7_no_word_on_err: assert property (@(posedge clk) disable iff (rst)
    cfg_err && !pk_valid |=> !pk_valid);

  a_r9_data_steady: assert property (@(posedge clk) disable iff (rst)
    !pk_valid |-> $stable(pk_data));
endmodule

bind adc_lane_packer adc_lane_packer_chk #(
  .NCHAN(NCHAN), .WOUT(WOUT), .NFIELD(NFIELD), .PW(PW)
) u_chk (
  .clk(clk), .rst(rst), .lane_en(lane_en), .smp_ready(smp_ready),
  .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_data(pk_data),
  .cfg_err(cfg_err), .fill_pos(fill_pos)
);

// File: tb/sim_adc_lane_packer.sv
`timescale 1ns/1ps
module sim_adc_lane_packer;
  localparam int NCHAN = 4, WIN = 8, WOUT = 64, NF = WOUT / WIN;

  logic clk = 0;
  logic rst;
  logic [NCHAN-1:0] lane_en;
  logic smp_valid, smp_ready, pk_valid, pk_ready, cfg_err;
  logic [NCHAN*WIN-1:0] smp_data;
  logic [WOUT-1:0] pk_data;

  always #5 clk = ~clk;

  adc_lane_packer #(.NCHAN(NCHAN), .WIN(WIN), .WOUT(WOUT)) u0 (
    .clk(clk), .rst(rst), .lane_en(lane_en), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .pk_valid(pk_valid),
    .pk_ready(pk_ready), .pk_data(pk_data), .cfg_err(cfg_err)
  );

  int n_chk = 0, n_bad = 0;
  int tcount = 0, fill = 0;
  logic [NCHAN-1:0] mdl_mask;
  logic [WIN-1:0] ef [NF];
  logic [WOUT-1:0] exp_word = '0;
  logic exp_v = 0;

  function automatic logic legal(input logic [NCHAN-1:0] m);
    int n = 0;
    for (int i = 0; i < NCHAN; i++) if (m[i]) n++;
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [WOUT-1:0] act, input logic [WOUT-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock of stimulus plus model update and output checks
  task automatic step(input logic [NCHAN-1:0] m, input logic v, input logic ord,
                      input string req);
    logic exp_rdy, acc;
    @(negedge clk);
    lane_en = m; smp_valid = v; pk_ready = ord;
    for (int c = 0; c < NCHAN; c++) smp_data[c*WIN +: WIN] = WIN'(c * 64 + tcount % 64);
    #1;
    exp_rdy = legal(mdl_mask) && (m == mdl_mask) && !(exp_v && !ord);
    check(smp_ready == exp_rdy, req, "smp_ready", 64'(smp_ready), 64'(exp_rdy));
    acc = v && exp_rdy;
    @(posedge clk); #1;
    if (exp_v && ord) exp_v = 0;
    if (m != mdl_mask) begin
      mdl_mask = m; fill = 0;
    end else if (acc) begin
      for (int c = 0; c < NCHAN; c++)
        if (m[c]) begin ef[fill] = WIN'(c * 64 + tcount % 64); fill++; end
      tcount++;
      if (fill == NF) begin
        for (int f = 0; f < NF; f++) exp_word[f*WIN +: WIN] = ef[f];
        exp_v = 1; fill = 0;
      end
    end
    check(pk_valid == exp_v, req, "pk_valid", 64'(pk_valid), 64'(exp_v));
    if (exp_v) check(pk_data == exp_word, req, "pk_data", pk_data, exp_word);
    else check(pk_data == exp_word, "R9", "pk_data held", pk_data, exp_word);
    check(cfg_err == !legal(mdl_mask), req, "cfg_err", 64'(cfg_err), 64'(!legal(mdl_mask)));
  endtask

  task automatic t_reset();
    lane_en = 4'b0001; smp_valid = 0; pk_ready = 1; smp_data = '0; rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    mdl_mask = 4'b0001;
    check(pk_valid == 0, "R8", "pk_valid", 64'(pk_valid), 0);
    check(cfg_err == 0, "R8", "cfg_err", 64'(cfg_err), 0);
    check(smp_ready == 1, "R8", "smp_ready", 64'(smp_ready), 1);
    check(pk_data == '0, "R8", "pk_data", pk_data, '0);
  endtask

  task automatic t_single_lane();
    for (int i = 0; i < 17; i++) step(4'b0001, 1, 1, "R1/R4");
    step(4'b0001, 0, 1, "R1");
    for (int i = 0; i < 17; i++) step(4'b0100, 1, 1, "R3");
  endtask

  task automatic t_pair();
    for (int i = 0; i < 13; i++) step(4'b0101, 1, 1, "R2");
  endtask

  task automatic t_quad();
    for (int i = 0; i < 9; i++) step(4'b1111, 1, 1, "R2/R4");
  endtask

  task automatic t_mask_midword();
    for (int i = 0; i < 7; i++) step(4'b0011, 1, 1, "R6");
    for (int i = 0; i < 5; i++) step(4'b1111, 1, 1, "R6");
  endtask

  task automatic t_illegal();
    for (int i = 0; i < 5; i++) step(4'b0111, 1, 1, "R7");
    for (int i = 0; i < 3; i++) step(4'b0000, 1, 1, "R7");
    for (int i = 0; i < 9; i++) step(4'b1000, 1, 1, "R7");
  endtask

  task automatic t_stall();
    for (int i = 0; i < 3; i++) step(4'b1111, 1, 1, "R5");
    for (int i = 0; i < 4; i++) step(4'b1111, 1, 0, "R5");
    for (int i = 0; i < 5; i++) step(4'b1111, 1, 1, "R5");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single_lane();
    t_pair();
    t_quad();
    t_mask_midword();
    t_illegal();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule